// File: doc/BRIEF.md
# Three-Slot Decode Steering with Micro-op Queue

This block sits between an instruction buffer and the rename stage. Each cycle it looks at the next three buffered instructions. Each instruction carries a valid bit, a micro-op count and an identifying tag. The block decides how many of them decode together. Only the first decode slot can take an instruction that expands to more than one micro-op. The two slots behind it take only single-micro-op instructions. The group that decodes is therefore the longest valid prefix that fits this shape, so the decode count depends on where complex instructions fall in the buffer.

The block writes the decoded micro-ops into a small circular queue toward rename. The queue holds one entry per micro-op, and each entry carries the instruction tag and the micro-op index within that instruction. An instruction that needs more micro-ops than the lead slot can produce supplies its first four micro-ops from the lead slot. It then posts a request to a microcode sequencer, which produces the remainder. The instructions behind it are not consumed and come back in the next cycle. The `consumed_o` count tells the buffer how far to advance.

Top module: `dec_steer`

## Requirements
- R1: Slot 0 accepts an instruction of any micro-op count from 1 to 7. Slots 1 and 2 join the group only when their count is exactly 1 and every slot ahead of them joined. The consumed count is 3 for simple,simple,simple and 2 for simple,simple,complex. It is 1 when slot 1 is complex, 3 for complex,simple,simple and 2 for complex,simple,complex.
- R2: `ib_valid_i` is a prefix mask (bit k for slot k). Only valid slots can join the group. With bit 0 clear, `consumed_o` is 0 and nothing is written.
- R3: A group needs a number of queue entries equal to its micro-op total. That total is the lead count (capped at 4) plus one for each further slot. The group decodes only when the free entries at the start of the cycle (six minus occupancy) cover the total. Otherwise `consumed_o` is 0 and no entry is written, so the queue never holds more than six entries.
- R4: A decoded group is visible at the queue head from the next cycle. The lead instruction's micro-ops come first, with index 0, 1 and so on, followed by slot 1 and then slot 2, each with index 0. One entry leaves per cycle while `dq_ready_i` is high and the queue is non-empty. Otherwise the head holds steady.
- R5: A slot-0 instruction of 5 to 7 micro-ops decodes alone (`consumed_o` = 1) and writes four queue entries, indices 0 to 3. In the next cycle `ms_valid_o` rises with that instruction's tag and with `ms_rem_o` equal to its count minus 4.
- R6: A sequencer request keeps its tag and remainder until a cycle in which `ms_ready_i` is high, and it clears after that edge. While the request is pending, `consumed_o` is 0.
- R7: After reset the queue is empty (`dq_valid_o` low) and no sequencer request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ib_valid_i | input | 3 | Valid prefix mask, bit k for slot k |
| ib_uops_i | input | 9 | Micro-op counts, 3 bits per slot, slot k at [3k+2:3k], legal values 1..7 |
| ib_tag_i | input | 24 | Instruction tags, 8 bits per slot, slot k at [8k+7:8k] |
| consumed_o | output | 2 | Instructions taken this cycle |
| dq_valid_o | output | 1 | Queue head holds a micro-op |
| dq_ready_i | input | 1 | Rename takes the head entry |
| dq_tag_o | output | 8 | Tag of the head micro-op |
| dq_idx_o | output | 2 | Index of the head micro-op within its instruction |
| ms_valid_o | output | 1 | Sequencer request pending |
| ms_ready_i | input | 1 | Sequencer accepts the request |
| ms_tag_o | output | 8 | Tag of the instruction handed to the sequencer |
| ms_rem_o | output | 3 | Micro-ops left for the sequencer |

## Verification
Any fault in the internal state shows at the ports within a few cycles. A corrupt write pointer or occupancy count shows up as a wrong tag or index at the queue head. It can also show up as an entry count that differs from the arithmetic micro-op total once the queue drains, or as a stall or a decode against the wrong free space in the very next group. A wrong steering decision shows up at once in `consumed_o` in the same cycle. A lost or early-cleared sequencer request shows in `ms_valid_o` one cycle later, and through the decode stall that depends on that request.

// File: rtl/dsteer_pkg.sv
`timescale 1ns/1ps
package dsteer_pkg;
  localparam int unsigned UOP_W  = 3;  // micro-op count field per slot
  localparam int unsigned IDX_W  = 2;  // micro-op index inside an instruction
  localparam int unsigned CX_MAX = 4;  // most micro-ops the lead slot emits
endpackage

// File: rtl/dsteer_pick.sv
`timescale 1ns/1ps
module dsteer_pick
  import dsteer_pkg::*;
#(
  parameter int unsigned NSLOT = 3,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CNT_W  = $clog2(NSLOT + 1),
  localparam int unsigned WMAX   = CX_MAX + NSLOT - 1,
  localparam int unsigned WN_W   = $clog2(WMAX + 1),
  localparam int unsigned FREE_W = $clog2(DEPTH + 1)
) (
  input  logic [NSLOT-1:0]       valid_i,
  input  logic [NSLOT*UOP_W-1:0] uops_i,
  input  logic [FREE_W-1:0]      free_i,
  input  logic                   busy_i,
  output logic [CNT_W-1:0]       take_o,
  output logic [WN_W-1:0]        wr_n_o,
  output logic [IDX_W:0]         lead_o,
  output logic                   long_o
);
  always_comb begin : steer
    int n;
    int tot;
    logic run;
    logic [UOP_W-1:0] u;
    u      = uops_i[UOP_W-1:0];
    long_o = valid_i[0] && (int'(u) > int'(CX_MAX));
    lead_o = long_o ? (IDX_W+1)'(CX_MAX) : (IDX_W+1)'(u);
    n   = 0;
    tot = 0;
    run = 1'b0;
    if (valid_i[0]) begin
      n   = 1;
      tot = int'(lead_o);
      run = !long_o;
    end
    // simple-only slots extend the group until the first miss
    for (int k = 1; k < int'(NSLOT); k++) begin
      if (run && valid_i[k] && (uops_i[k*UOP_W +: UOP_W] == UOP_W'(1))) begin
        n   = n + 1;
        tot = tot + 1;
      end else begin
        run = 1'b0;
      end
    end
    // all-or-nothing: stall the whole group
    if (busy_i || (tot > int'(free_i))) begin
      n   = 0;
      tot = 0;
    end
    take_o = CNT_W'(n);
    wr_n_o = WN_W'(tot);
  end
endmodule

// File: rtl/dsteer_uopq.sv
`timescale 1ns/1ps
module dsteer_uopq
  import dsteer_pkg::*;
#(
  parameter int unsigned NSLOT = 3,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned WMAX   = CX_MAX + NSLOT - 1,
  localparam int unsigned WN_W   = $clog2(WMAX + 1),
  localparam int unsigned FREE_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [WN_W-1:0]        wr_n_i,
  input  logic [IDX_W:0]         lead_i,
  input  logic [NSLOT*TAG_W-1:0] tags_i,
  input  logic                   pop_i,
  output logic                   valid_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [FREE_W-1:0]      free_o
);
  logic [TAG_W-1:0]  ln_tag [WMAX];
  logic [IDX_W-1:0]  ln_idx [WMAX];
  logic [TAG_W-1:0]  mem_tag [DEPTH];
  logic [IDX_W-1:0]  mem_idx [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [FREE_W-1:0] cnt;
  logic              pop;

  function automatic logic [PTR_W-1:0] wrap(input int a);
    return PTR_W'(a % int'(DEPTH));
  endfunction

  // lane j: lead micro-ops first, then one per trailing slot
  always_comb begin
    for (int j = 0; j < int'(WMAX); j++) begin
      int k;
      k = j - int'(lead_i) + 1;
      if (j < int'(lead_i)) begin
        ln_tag[j] = tags_i[TAG_W-1:0];
        ln_idx[j] = IDX_W'(j);
      end else begin
        ln_tag[j] = (k < int'(NSLOT)) ? tags_i[k*TAG_W +: TAG_W] : '0;
        ln_idx[j] = '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < int'(WMAX); j++) begin
      if (j < int'(wr_n_i)) begin
        mem_tag[wrap(int'(wptr) + j)] <= ln_tag[j];
        mem_idx[wrap(int'(wptr) + j)] <= ln_idx[j];
      end
    end
  end

  assign pop = pop_i && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wrap(int'(wptr) + int'(wr_n_i));
      if (pop) rptr <= wrap(int'(rptr) + 1);
      cnt <= FREE_W'(int'(cnt) + int'(wr_n_i) - (pop ? 1 : 0));
    end
  end

  assign valid_o = (cnt != '0);
  assign tag_o   = mem_tag[rptr];
  assign idx_o   = mem_idx[rptr];
  assign free_o  = FREE_W'(int'(DEPTH) - int'(cnt));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_n_i) <= int'(DEPTH) - int'(cnt));

  assert_head_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(tag_o) && $stable(idx_o)));
endmodule

// File: rtl/dsteer_mshand.sv
`timescale 1ns/1ps
module dsteer_mshand
  import dsteer_pkg::*;
#(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [UOP_W-1:0] rem_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [UOP_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      rem_o   <= '0;
    end else if (launch_i) begin
      valid_o <= 1'b1;
      tag_o   <= tag_i;
      rem_o   <= rem_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(tag_o) && $stable(rem_o)));

  assert_no_launch_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !valid_o);
endmodule

// File: rtl/dec_steer.sv
`timescale 1ns/1ps
module dec_steer
  import dsteer_pkg::*;
#(
  parameter int unsigned NSLOT = 3,
  parameter int unsigned DEPTH = 6,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned CNT_W  = $clog2(NSLOT + 1),
  localparam int unsigned WMAX   = CX_MAX + NSLOT - 1,
  localparam int unsigned WN_W   = $clog2(WMAX + 1),
  localparam int unsigned FREE_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT-1:0]       ib_valid_i,
  input  logic [NSLOT*UOP_W-1:0] ib_uops_i,
  input  logic [NSLOT*TAG_W-1:0] ib_tag_i,
  output logic [CNT_W-1:0]       consumed_o,
  output logic                   dq_valid_o,
  input  logic                   dq_ready_i,
  output logic [TAG_W-1:0]       dq_tag_o,
  output logic [IDX_W-1:0]       dq_idx_o,
  output logic                   ms_valid_o,
  input  logic                   ms_ready_i,
  output logic [TAG_W-1:0]       ms_tag_o,
  output logic [UOP_W-1:0]       ms_rem_o
);
  logic [WN_W-1:0]   wr_n;
  logic [IDX_W:0]    lead;
  logic              head_long;
  logic [FREE_W-1:0] free;
  logic              launch;

  dsteer_pick #(.NSLOT(NSLOT), .DEPTH(DEPTH)) u_pick (
    .valid_i (ib_valid_i),
    .uops_i  (ib_uops_i),
    .free_i  (free),
    .busy_i  (ms_valid_o),
    .take_o  (consumed_o),
    .wr_n_o  (wr_n),
    .lead_o  (lead),
    .long_o  (head_long)
  );

  dsteer_uopq #(.NSLOT(NSLOT), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_n_i  (wr_n),
    .lead_i  (lead),
    .tags_i  (ib_tag_i),
    .pop_i   (dq_ready_i),
    .valid_o (dq_valid_o),
    .tag_o   (dq_tag_o),
    .idx_o   (dq_idx_o),
    .free_o  (free)
  );

  assign launch = head_long && (consumed_o != '0);

  dsteer_mshand #(.TAG_W(TAG_W)) u_ms (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .tag_i    (ib_tag_i[TAG_W-1:0]),
    .rem_i    (UOP_W'(ib_uops_i[UOP_W-1:0] - UOP_W'(CX_MAX))),
    .ready_i  (ms_ready_i),
    .valid_o  (ms_valid_o),
    .tag_o    (ms_tag_o),
    .rem_o    (ms_rem_o)
  );

  assert_lead_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consumed_o != '0) |-> ib_valid_i[0]);

  assert_busy_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_valid_o |-> (consumed_o == '0));

  assert_long_handoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (ms_valid_o && (ms_rem_o == UOP_W'($past(ib_uops_i[UOP_W-1:0]) - UOP_W'(CX_MAX)))));

  assert_long_alone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |-> (consumed_o == CNT_W'(1)));
endmodule

// File: tb/sim_dec_steer.sv
`timescale 1ns/1ps
module sim_dec_steer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ib_valid_i = '0;
  logic [8:0] ib_uops_i = '0;
  logic [23:0] ib_tag_i = '0;
  logic [1:0] consumed_o;
  logic       dq_valid_o;
  logic       dq_ready_i = 1'b0;
  logic [7:0] dq_tag_o;
  logic [1:0] dq_idx_o;
  logic       ms_valid_o;
  logic       ms_ready_i = 1'b0;
  logic [7:0] ms_tag_o;
  logic [2:0] ms_rem_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dec_steer u0 (.*);

  function automatic int tg(int k, int salt);
    return (k + 1) * 16 + (salt % 16);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(int c, int a, int b, int d, int salt);
    ib_valid_i = 3'((1 << c) - 1);
    ib_uops_i  = {3'(d), 3'(b), 3'(a)};
    ib_tag_i   = {8'(tg(2, salt)), 8'(tg(1, salt)), 8'(tg(0, salt))};
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // pop one entry and check it
  task automatic pop_chk(string req, int etag, int eidx);
    chk(req, "dq_valid", int'(dq_valid_o), 1);
    chk(req, "dq_tag", int'(dq_tag_o), etag);
    chk(req, "dq_idx", int'(dq_idx_o), eidx);
    dq_ready_i = 1'b1;
    step();
    dq_ready_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    step();
    // R7 reset state
    chk("R7", "dq_valid", int'(dq_valid_o), 0);
    chk("R7", "ms_valid", int'(ms_valid_o), 0);
    chk("R2", "consumed none valid", int'(consumed_o), 0);

    // R1 R2 R4 R5 sweep from an empty queue
    for (int c = 0; c <= 3; c++)
      for (int a = 1; a <= 7; a++)
        for (int b = 1; b <= 7; b++)
          for (int d = 1; d <= 7; d++) begin
            int salt, n, la, tot;
            salt = a * 7 + b * 3 + d + c;
            n = 0;
            if (c >= 1) n = 1;
            if (n == 1 && a <= 4 && c >= 2 && b == 1) n = 2;
            if (n == 2 && c >= 3 && d == 1) n = 3;
            la  = (a > 4) ? 4 : a;
            tot = (n > 0) ? la + n - 1 : 0;
            put(c, a, b, d, salt);
            #1;
            chk("R1", "consumed", int'(consumed_o), n);
            step();
            ib_valid_i = '0;
            for (int j = 0; j < tot; j++) begin
              if (j < la) pop_chk("R4", tg(0, salt), j);
              else        pop_chk("R4", tg(j - la + 1, salt), 0);
            end
            chk("R4", "dq_valid drained", int'(dq_valid_o), 0);
            if (n > 0 && a > 4) begin
              chk("R5", "ms_valid", int'(ms_valid_o), 1);
              chk("R5", "ms_tag", int'(ms_tag_o), tg(0, salt));
              chk("R5", "ms_rem", int'(ms_rem_o), a - 4);
              ms_ready_i = 1'b1;
              step();
              ms_ready_i = 1'b0;
              chk("R6", "ms_valid cleared", int'(ms_valid_o), 0);
            end else begin
              chk("R5", "no ms request", int'(ms_valid_o), 0);
            end
          end

    // R3 queue full stall
    put(3, 4, 1, 1, 3);
    #1;
    chk("R3", "fill group", int'(consumed_o), 3);
    step();
    put(1, 1, 1, 1, 4);
    #1;
    chk("R3", "full stall", int'(consumed_o), 0);
    put(2, 1, 1, 1, 4);
    dq_ready_i = 1'b1;
    #1;
    chk("R3", "stall with pop same cycle", int'(consumed_o), 0);
    step();
    dq_ready_i = 1'b0;
    put(2, 1, 1, 1, 4);
    #1;
    chk("R3", "two need one free", int'(consumed_o), 0);
    put(1, 1, 1, 1, 9);
    #1;
    chk("R3", "one fits one free", int'(consumed_o), 1);
    step();
    ib_valid_i = '0;
    for (int j = 1; j < 4; j++) pop_chk("R3", tg(0, 3), j);
    pop_chk("R3", tg(1, 3), 0);
    pop_chk("R3", tg(2, 3), 0);
    pop_chk("R3", tg(0, 9), 0);
    chk("R3", "no stalled writes", int'(dq_valid_o), 0);

    // R6 pending sequencer request
    put(3, 6, 1, 1, 5);
    #1;
    chk("R5", "long alone", int'(consumed_o), 1);
    step();
    put(1, 1, 1, 1, 6);
    #1;
    chk("R6", "stall while pending", int'(consumed_o), 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6", "ms_valid held", int'(ms_valid_o), 1);
      chk("R6", "ms_tag held", int'(ms_tag_o), tg(0, 5));
      chk("R6", "ms_rem held", int'(ms_rem_o), 2);
      chk("R6", "consumed held 0", int'(consumed_o), 0);
    end
    ms_ready_i = 1'b1;
    #1;
    chk("R6", "stall on accept cycle", int'(consumed_o), 0);
    step();
    ms_ready_i = 1'b0;
    chk("R6", "ms_valid cleared", int'(ms_valid_o), 0);
    chk("R6", "decode resumes", int'(consumed_o), 1);
    step();
    ib_valid_i = '0;
    for (int j = 0; j < 4; j++) pop_chk("R5", tg(0, 5), j);
    pop_chk("R6", tg(0, 6), 0);
    chk("R4", "dq_valid drained", int'(dq_valid_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule